// File: doc/BRIEF.md
# SECDED-Protected Memory with Background Scrubbing

This block puts single-error-correct, double-error-detect protection around a single-port synchronous RAM. Every 32-bit word goes into the array together with six Hamming check bits and one overall parity bit, which makes a 39-bit stored codeword. On a read, the block corrects any single flipped bit before it returns the data. It also reports whether the word needed a correction or could not be corrected.

Correcting on the read path does not change the stored word. A single upset left in place can later combine with a second upset and become a double error. To prevent this, a scrub engine runs while the host is idle. It visits the addresses in turn, reads each word and decodes it. When it finds a correctable error, it writes the re-encoded word back to the array. Host traffic always takes precedence, and the scrubber only uses cycles in which the host presents no request. A programmable count of idle cycles spaces out the scrub steps. Two saturating counters and a last-error address give a running record of corrected and uncorrectable reads.

Top module: `secded_mem_scrub`

## Requirements
- R1: A word written by the host is returned unchanged by a later host read. The response (rsp_valid_o high) appears exactly one cycle after the read is accepted, and at no other time. For a clean word, both error flags are low.
- R2: If any one bit of the 39-bit stored codeword is inverted (data, Hamming check or overall parity bit), a host read returns the original data with rsp_corr_o=1 and rsp_uncorr_o=0.
- R3: If any two distinct bits of the stored codeword are inverted, a host read reports rsp_uncorr_o=1 and rsp_corr_o=0.
- R4: A corrected host read does not repair the array. Reading the same single-error word again reports rsp_corr_o=1 again.
- R5: When scrub_en_i is high, the scrubber visits every address in ascending order and wraps from DEPTH-1 to 0. It rewrites each word that holds a single error with its corrected codeword, so later host reads of that word are clean. Each repaired word raises the corrected count exactly once.
- R6: A word that the scrubber finds uncorrectable is not written back. A later host read still reports rsp_uncorr_o=1.
- R7: req_ready_o is always high, so the host never stalls. The scrubber never reads or writes the array in a cycle that carries a host request. Host read results are unaffected by scrub activity.
- R8: The cycles between two scrub reads include at least scrub_interval_i cycles without a host request. The idle count restarts from zero while scrubbing is disabled.
- R9: corr_cnt_o and uncorr_cnt_o rise by one for each read, host or scrub, that finds a correctable or an uncorrectable error respectively. Both counters saturate at their maximum. last_err_addr_o holds the address of the most recent read that found either kind of error.
- R10: After reset, rsp_valid_o is low, req_ready_o is high, both counters are zero and last_err_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Host request accepted (always high) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response present |
| rsp_rdata_o | output | 32 | Corrected read data |
| rsp_corr_o | output | 1 | Response word held a correctable error |
| rsp_uncorr_o | output | 1 | Response word held an uncorrectable error |
| scrub_en_i | input | 1 | Enable background scrubbing |
| scrub_interval_i | input | CNT_W | Idle cycles between scrub steps |
| corr_cnt_o | output | CNT_W | Saturating count of corrected reads |
| uncorr_cnt_o | output | CNT_W | Saturating count of uncorrectable reads |
| last_err_addr_o | output | AW | Address of the most recent erroneous read |

## Verification
A host read response is due in the cycle right after the request edge. The bench drives requests on the falling edge, and its monitor pops the expected word on the next falling edge, so every response is compared in exactly its own cycle. Counter and last-address updates land one edge after the response, and the bench reads them only after two idle falling edges. Scrub repairs are checked only after a wait that covers several full passes with a zero interval. The spacing of scrub steps is checked with windows placed well inside and well past the first step at an interval of 100, so that it does not depend on cycle-exact alignment.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W = 32;

  function automatic int unsigned ham_bits(int unsigned dw);
    int unsigned r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  localparam int unsigned HAM_W  = ham_bits(DATA_W);
  localparam int unsigned CODE_W = DATA_W + HAM_W + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [HAM_W-1:0]  syn_t;

  typedef enum logic [1:0] {S_WAIT, S_RD, S_CHK, S_WB} scrub_state_e;

  // bit 0 is overall parity, power-of-two positions carry Hamming checks
  function automatic logic is_pow2(int unsigned p);
    return (p & (p - 1)) == 0;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  data_t data_i,
  output code_t code_o
);
  always_comb begin
    code_t c;
    int unsigned k;
    logic x;
    c = '0;
    k = 0;
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        c[p] = data_i[k];
        k++;
      end
    end
    for (int unsigned j = 0; j < HAM_W; j++) begin
      x = 1'b0;
      for (int unsigned p = 1; p < CODE_W; p++) begin
        if (p[j] && !is_pow2(p)) x = x ^ c[p];
      end
      c[1 << j] = x;
    end
    c[0] = ^c;
    code_o = c;
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  code_t code_i,
  output data_t data_o,
  output logic  corr_o,
  output logic  uncorr_o
);
  always_comb begin
    syn_t s;
    logic par;
    logic in_rng;
    code_t c;
    data_t d;
    int unsigned k;
    s = '0;
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (code_i[p]) s = s ^ syn_t'(p);
    end
    par    = ^code_i;
    in_rng = int'(s) < int'(CODE_W);
    c = code_i;
    if (par && in_rng) c[s] = ~c[s];
    corr_o   = par && in_rng;
    uncorr_o = (!par && (s != '0)) || (par && !in_rng);
    d = '0;
    k = 0;
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        d[k] = c[p];
        k++;
      end
    end
    data_o = d;
  end
endmodule

// File: rtl/spram.sv
module spram #(
  parameter int unsigned WIDTH = 39,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import secded_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             host_valid_i,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  data_t            dec_data_i,
  input  logic             dec_corr_i,
  output logic             rd_o,
  output logic             chk_o,
  output logic             wb_o,
  output logic [AW-1:0]    addr_o,
  output data_t            wb_data_o
);
  scrub_state_e     st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    addr_q, addr_d, addr_nxt;
  data_t            wb_q, wb_d;
  logic             hit;

  // a host write to the word under scrub makes the held copy stale
  assign hit      = host_valid_i && host_we_i && (host_addr_i == addr_q);
  assign addr_nxt = (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    wb_d   = wb_q;
    rd_o   = 1'b0;
    wb_o   = 1'b0;
    chk_o  = (st_q == S_CHK);
    unique case (st_q)
      S_WAIT: begin
        if (!en_i) cnt_d = '0;
        else if (!host_valid_i) begin
          if (cnt_q >= interval_i) begin
            cnt_d = '0;
            st_d  = S_RD;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      S_RD: begin
        if (!en_i) st_d = S_WAIT;
        else if (!host_valid_i) begin
          rd_o = 1'b1;
          st_d = S_CHK;
        end
      end
      S_CHK: begin
        if (dec_corr_i && !hit) begin
          wb_d = dec_data_i;
          st_d = S_WB;
        end else begin
          addr_d = addr_nxt;
          st_d   = S_WAIT;
        end
      end
      S_WB: begin
        if (hit) begin
          addr_d = addr_nxt;
          st_d   = S_WAIT;
        end else if (!host_valid_i) begin
          wb_o   = 1'b1;
          addr_d = addr_nxt;
          st_d   = S_WAIT;
        end
      end
      default: st_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_WAIT;
      cnt_q  <= '0;
      addr_q <= '0;
      wb_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      wb_q   <= wb_d;
    end
  end

  assign addr_o    = addr_q;
  assign wb_data_o = wb_q;
endmodule

// File: rtl/secded_mem_scrub.sv
module secded_mem_scrub
  import secded_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_corr_o,
  output logic              rsp_uncorr_o,
  input  logic              scrub_en_i,
  input  logic [CNT_W-1:0]  scrub_interval_i,
  output logic [CNT_W-1:0]  corr_cnt_o,
  output logic [CNT_W-1:0]  uncorr_cnt_o,
  output logic [AW-1:0]     last_err_addr_o
);
  data_t         enc_in, dec_data, scrub_wb_data;
  code_t         ram_wdata, ram_rdata;
  logic          ram_we;
  logic [AW-1:0] ram_addr, scrub_addr, rd_addr_q;
  logic          scrub_rd, scrub_wb, scrub_chk;
  logic          dec_corr, dec_uncorr;
  logic          rd_host_q, chk_ev;
  logic [CNT_W-1:0] corr_cnt_q, uncorr_cnt_q;
  logic [AW-1:0]    last_err_q;

  assign req_ready_o = 1'b1;

  // host owns the array whenever it presents a request
  assign enc_in   = req_valid_i ? req_wdata_i : scrub_wb_data;
  assign ram_we   = (req_valid_i && req_we_i) || scrub_wb;
  assign ram_addr = req_valid_i ? req_addr_i : scrub_addr;

  secded_enc u_enc (.data_i(enc_in), .code_o(ram_wdata));

  spram #(.WIDTH(CODE_W), .DEPTH(DEPTH)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (ram_addr),
    .wdata_i(ram_wdata),
    .rdata_o(ram_rdata)
  );

  secded_dec u_dec (
    .code_i  (ram_rdata),
    .data_o  (dec_data),
    .corr_o  (dec_corr),
    .uncorr_o(dec_uncorr)
  );

  scrub_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_scrub (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (scrub_en_i),
    .interval_i  (scrub_interval_i),
    .host_valid_i(req_valid_i),
    .host_we_i   (req_we_i),
    .host_addr_i (req_addr_i),
    .dec_data_i  (dec_data),
    .dec_corr_i  (dec_corr),
    .rd_o        (scrub_rd),
    .chk_o       (scrub_chk),
    .wb_o        (scrub_wb),
    .addr_o      (scrub_addr),
    .wb_data_o   (scrub_wb_data)
  );

  assign chk_ev = rd_host_q || scrub_chk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_host_q    <= 1'b0;
      rd_addr_q    <= '0;
      corr_cnt_q   <= '0;
      uncorr_cnt_q <= '0;
      last_err_q   <= '0;
    end else begin
      rd_host_q <= req_valid_i && !req_we_i;
      rd_addr_q <= ram_addr;
      if (chk_ev && dec_corr) begin
        last_err_q <= rd_addr_q;
        if (corr_cnt_q != '1) corr_cnt_q <= corr_cnt_q + 1'b1;
      end
      if (chk_ev && dec_uncorr) begin
        last_err_q <= rd_addr_q;
        if (uncorr_cnt_q != '1) uncorr_cnt_q <= uncorr_cnt_q + 1'b1;
      end
    end
  end

  assign rsp_valid_o     = rd_host_q;
  assign rsp_rdata_o     = dec_data;
  assign rsp_corr_o      = rd_host_q && dec_corr;
  assign rsp_uncorr_o    = rd_host_q && dec_uncorr;
  assign corr_cnt_o      = corr_cnt_q;
  assign uncorr_cnt_o    = uncorr_cnt_q;
  assign last_err_addr_o = last_err_q;
endmodule

// File: rtl/secded_mem_scrub_chk.sv
module secded_mem_scrub_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_we_i,
  input logic             rsp_valid_o,
  input logic             rsp_corr_o,
  input logic             rsp_uncorr_o,
  input logic [CNT_W-1:0] corr_cnt_o,
  input logic             scrub_en_i,
  input logic [CNT_W-1:0] scrub_interval_i,
  input logic             scrub_rd,
  input logic             scrub_wb,
  input logic             scrub_chk,
  input logic             dec_uncorr
);
  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else if (scrub_rd || !scrub_en_i) gap_q <= '0;
    else if (!req_valid_i && gap_q != '1) gap_q <= gap_q + 1'b1;
  end

  a_r1_rsp_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |=> rsp_valid_o);

  a_r1_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_we_i) |=> !rsp_valid_o);

  a_r3_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_corr_o && rsp_uncorr_o));

  a_r6_no_wb_after_uncorr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scrub_chk && dec_uncorr) |=> !scrub_wb);

  a_r7_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> !(scrub_rd || scrub_wb));

  a_r8_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_rd |-> (gap_q >= scrub_interval_i));

  a_r9_corr_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (corr_cnt_o >= $past(corr_cnt_o)));
endmodule

bind secded_mem_scrub secded_mem_scrub_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_we_i        (req_we_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_corr_o      (rsp_corr_o),
  .rsp_uncorr_o    (rsp_uncorr_o),
  .corr_cnt_o      (corr_cnt_o),
  .scrub_en_i      (scrub_en_i),
  .scrub_interval_i(scrub_interval_i),
  .scrub_rd        (scrub_rd),
  .scrub_wb        (scrub_wb),
  .scrub_chk       (scrub_chk),
  .dec_uncorr      (dec_uncorr)
);

// File: tb/tb_secded_mem_scrub.sv
`timescale 1ns/1ps
module tb_secded_mem_scrub;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int CNT_W = 16;
  localparam int CW    = 39;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_we = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [31:0]      req_wdata = '0;
  logic             rsp_valid;
  logic [31:0]      rsp_rdata;
  logic             rsp_corr, rsp_uncorr;
  logic             scrub_en = 1'b0;
  logic [CNT_W-1:0] scrub_interval = '0;
  logic [CNT_W-1:0] corr_cnt, uncorr_cnt;
  logic [AW-1:0]    last_err_addr;

  always #2.5 clk = ~clk;

  secded_mem_scrub #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_corr_o(rsp_corr), .rsp_uncorr_o(rsp_uncorr),
    .scrub_en_i(scrub_en), .scrub_interval_i(scrub_interval),
    .corr_cnt_o(corr_cnt), .uncorr_cnt_o(uncorr_cnt),
    .last_err_addr_o(last_err_addr)
  );

  typedef struct packed {
    logic [31:0] d;
    logic        c;
    logic        u;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [31:0] shadow [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: each response is compared in the cycle after its request
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R1", "unexpected response", 64'(rsp_rdata), 64'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check((e.u || rsp_rdata == e.d) && rsp_corr == e.c && rsp_uncorr == e.u,
              e.u ? "R3" : (e.c ? "R2" : "R1"), "read response",
              {rsp_rdata, 30'd0, rsp_corr, rsp_uncorr}, {e.d, 30'd0, e.c, e.u});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_we    = 1'b0;
    end
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
    shadow[a] = d;
  endtask

  task automatic do_read(input int a, input bit c, input bit u);
    @(negedge clk);
    check(req_ready == 1'b1, "R7", "ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
    exp_q.push_back('{d: shadow[a], c: c, u: u});
  endtask

  task automatic flip(input int a, input int b);
    @(negedge clk);
    dut.u_ram.mem_q[a][b] = ~dut.u_ram.mem_q[a][b];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int base_c, base_u;
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rsp_valid == 1'b0, "R10", "rsp_valid", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R10", "ready", 64'(req_ready), 64'd1);
    check(corr_cnt == '0 && uncorr_cnt == '0, "R10", "counters",
          {32'(corr_cnt), 32'(uncorr_cnt)}, 64'd0);
    check(last_err_addr == '0, "R10", "last addr", 64'(last_err_addr), 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R1: patterns, back-to-back reads
    do_write(0, 32'hFFFF_FFFF);
    do_write(1, 32'h0000_0000);
    do_write(2, 32'hAAAA_AAAA);
    do_write(3, 32'h5555_5555);
    for (int i = 4; i < DEPTH; i++) do_write(i, 32'h0000_0001 << (i % 32) ^ 32'(i * 32'h0101_037B));
    idle(1);
    for (int i = 0; i < 8; i++) do_read(i, 1'b0, 1'b0);
    do_read(63, 1'b0, 1'b0);
    idle(2);
    do_read(5, 1'b0, 1'b0);
    idle(3);

    // R2: every single-bit position of the codeword
    for (int b = 0; b < CW; b++) begin
      flip(10, b);
      do_read(10, 1'b1, 1'b0);
      idle(1);
      flip(10, b);
    end
    idle(2);
    check(corr_cnt == 16'd39, "R9", "corr count after single flips", 64'(corr_cnt), 64'd39);
    check(last_err_addr == 6'd10, "R9", "last addr", 64'(last_err_addr), 64'd10);

    // R4: read path correction leaves the stored error
    flip(11, 5);
    do_read(11, 1'b1, 1'b0);
    do_read(11, 1'b1, 1'b0);
    idle(2);
    check(corr_cnt == 16'd41, "R4", "corr count after repeat reads", 64'(corr_cnt), 64'd41);
    flip(11, 5);

    // R3: double flips
    flip(12, 0);  flip(12, 38); do_read(12, 1'b0, 1'b1); idle(1); flip(12, 0);  flip(12, 38);
    flip(12, 3);  flip(12, 17); do_read(12, 1'b0, 1'b1); idle(1); flip(12, 3);  flip(12, 17);
    flip(12, 20); flip(12, 21); do_read(12, 1'b0, 1'b1); idle(1); flip(12, 20); flip(12, 21);
    idle(2);
    check(uncorr_cnt == 16'd3, "R3", "uncorr count", 64'(uncorr_cnt), 64'd3);
    check(last_err_addr == 6'd12, "R9", "last addr after double", 64'(last_err_addr), 64'd12);

    // R5/R6: scrub repairs singles (incl. last address, wrap), keeps doubles
    base_c = int'(corr_cnt);
    base_u = int'(uncorr_cnt);
    flip(20, 9);
    flip(63, 30);
    flip(30, 1); flip(30, 2);
    scrub_interval = '0;
    scrub_en = 1'b1;
    idle(700);
    scrub_en = 1'b0;
    idle(6);
    check(int'(corr_cnt) == base_c + 2, "R5", "scrub repairs counted once",
          64'(corr_cnt), 64'(base_c + 2));
    check(int'(uncorr_cnt) > base_u, "R9", "scrub uncorr counted",
          64'(uncorr_cnt), 64'(base_u + 1));
    do_read(20, 1'b0, 1'b0);
    do_read(63, 1'b0, 1'b0);
    do_read(30, 1'b0, 1'b1);
    idle(2);
    check(last_err_addr == 6'd30, "R6", "uncorrectable word still flagged",
          64'(last_err_addr), 64'd30);
    flip(30, 1); flip(30, 2);

    // R7: host traffic while scrub runs
    scrub_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 0) do_write(40 + i, 32'hC0DE_0000 + 32'(i));
      else do_read(40 + (i % 12), 1'b0, 1'b0);
    end
    do_read(45, 1'b0, 1'b0);
    idle(3);
    scrub_en = 1'b0;
    idle(6);

    // R8: scrub step spacing, single error planted in every word
    for (int i = 0; i < DEPTH; i++) flip(i, 7);
    scrub_interval = 16'd100;
    base_c = int'(corr_cnt);
    @(negedge clk);
    scrub_en = 1'b1;
    idle(50);
    check(int'(corr_cnt) == base_c, "R8", "no scrub step before interval",
          64'(corr_cnt), 64'(base_c));
    idle(100);
    check(int'(corr_cnt) == base_c + 1, "R8", "one scrub step after interval",
          64'(corr_cnt), 64'(base_c + 1));
    scrub_en = 1'b0;
    idle(6);
    check(exp_q.size() == 0, "R1", "outstanding responses", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule